// File: doc/BRIEF.md
# Byte-Wide Configuration Load Port

This block is an asynchronous, processor-style write port. It accepts configuration bytes from a host bus and holds them in a one-byte buffer until a downstream serializer takes them. The host drives a pair of chip selects, a write strobe and a read strobe. None of these is related to the system clock, so each one passes through a synchronizer before the port acts on it.

A write stores the byte into the buffer. The capture happens when the write strobe is released, so the data bus is settled by then. A read strobe never returns the stored byte. Instead, the top data line turns into a ready/busy flag and every other line is driven high. The host polls this flag before it sends the next byte.

The buffer stays full until the serializer acknowledges it. A write that arrives while the buffer is still full is dropped, and a sticky overrun flag records that this happened.

Top module: `cfg_byte_port`

## Requirements
- R1: The port is selected only when `sel_n_i` is 0 and `sel_i` is 1 together. When the port is not selected, both strobes have no effect: `byte_o` and `byte_vld_o` do not change, and `bus_oe_o` stays 0.
- R2: While the port is selected, a write strobe (`wr_n_i` low, then high) loads the value on `bus_i` into the buffer. After the strobe rises, `byte_o` shows that value and `byte_vld_o` is 1 within 4 clock cycles.
- R3: While the port is selected, holding `rd_n_i` low sets `bus_oe_o` to 1 within 4 clock cycles. During that time, `bus_o[7]` reads 1 (ready) when `byte_vld_o` is 0 and reads 0 (busy) when `byte_vld_o` is 1.
- R4: During a status read, `bus_o[6:0]` are all 1.
- R5: When `wr_n_i` and `rd_n_i` are low together, the write wins. `bus_oe_o` stays 0, and the byte is captured when the write strobe is released.
- R6: `byte_vld_o` stays 1 from the capture until `byte_ack_i` is sampled 1. It reads 0 in the following cycle, unless a new byte is committed in that same cycle.
- R7: A write committed while `byte_vld_o` is 1 and `byte_ack_i` is 0 leaves `byte_o` unchanged and sets `overrun_o`. `overrun_o` then stays 1 until reset.
- R8: When a write commits in the same cycle that `byte_ack_i` frees the buffer, the new byte is accepted: `byte_vld_o` stays 1, `byte_o` takes the new value, and `overrun_o` stays 0.
- R9: `bus_oe_o` is 0 whenever no status read is active. After reset, `bus_oe_o`, `byte_vld_o` and `overrun_o` are all 0.
- R10: While `byte_vld_o` is 1 and no acknowledge arrives, `byte_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n_i | input | 1 | Chip select, active low |
| sel_i | input | 1 | Chip select, active high |
| wr_n_i | input | 1 | Write strobe, active low |
| rd_n_i | input | 1 | Status read strobe, active low |
| bus_i | input | 8 | Data bus, pad input side |
| bus_o | output | 8 | Data bus, pad output side (status word) |
| bus_oe_o | output | 1 | Data bus output enable |
| byte_o | output | 8 | Buffered byte for the serializer |
| byte_vld_o | output | 1 | Buffered byte is pending |
| byte_ack_i | input | 1 | Serializer acknowledges the pending byte |
| overrun_o | output | 1 | Sticky flag: a write was dropped while busy |

## Verification
Two events can land in the same clock cycle: a write commit and the serializer's acknowledge. The synchronizer delay is fixed, so the bench can count cycles from the moment it releases the write strobe and raise `byte_ack_i` in exactly the cycle the commit happens. It then checks that the new byte replaces the old one, that `byte_vld_o` stays high and that no overrun is flagged. A second test keeps the acknowledge low for that collision; there the old byte must survive and the overrun flag must rise.

// File: rtl/cbp_pkg.sv
package cbp_pkg;

    localparam int unsigned CBP_DATA_W = 8;

    // Pin bundle after synchronization, all in raw polarity
    typedef struct packed {
        logic                  sel_n;
        logic                  sel;
        logic                  wr_n;
        logic                  rd_n;
        logic [CBP_DATA_W-1:0] bus;
    } cbp_pins_t;

    localparam int unsigned CBP_PINS_W = $bits(cbp_pins_t);

    // Idle level of the pins: deselected, strobes released
    localparam cbp_pins_t CBP_PINS_IDLE = '{
        sel_n: 1'b1,
        sel:   1'b0,
        wr_n:  1'b1,
        rd_n:  1'b1,
        bus:   '0
    };

endpackage

// File: rtl/cbp_sync.sv
module cbp_sync #(
    parameter int unsigned    W      = 4,
    parameter int unsigned    STAGES = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [W-1:0] stage_d;
        if (g == 0) begin : g_first
            assign stage_d = async_i;
        end else begin : g_next
            assign stage_d = stage_q[g-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= RST_VAL;
            else        stage_q[g] <= stage_d;
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/cbp_strobe_decode.sv
module cbp_strobe_decode
    import cbp_pkg::*;
#(
    parameter int unsigned DATA_W = CBP_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n_s,
    input  logic              sel_s,
    input  logic              wr_n_s,
    input  logic              rd_n_s,
    input  logic [DATA_W-1:0] bus_s,
    output logic              commit_o,
    output logic [DATA_W-1:0] hold_o,
    output logic              rd_act_o
);

    typedef struct packed {
        logic              wr_act;
        logic [DATA_W-1:0] hold;
    } dec_state_t;

    dec_state_t st_d, st_q;
    logic       selected;
    logic       wr_act;

    always_comb begin
        selected = !sel_n_s && sel_s;
        wr_act   = selected && !wr_n_s;
        st_d        = st_q;
        st_d.wr_act = wr_act;
        // Track the bus while the strobe is held; released edge commits it
        if (wr_act) st_d.hold = bus_s;
        commit_o = st_q.wr_act && !wr_act;
        // Write overrides a simultaneous read
        rd_act_o = selected && !rd_n_s && wr_n_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hold_o = st_q.hold;

endmodule

// File: rtl/cbp_byte_buffer.sv
module cbp_byte_buffer
    import cbp_pkg::*;
#(
    parameter int unsigned DATA_W = CBP_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic [DATA_W-1:0] hold_i,
    input  logic              ack_i,
    output logic [DATA_W-1:0] byte_o,
    output logic              vld_o,
    output logic              ovr_o
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              vld;
        logic              ovr;
    } buf_state_t;

    buf_state_t st_d, st_q;
    logic       free;

    always_comb begin
        st_d = st_q;
        // An acknowledge in this cycle frees the slot for a same-cycle write
        free = !st_q.vld || ack_i;
        if (st_q.vld && ack_i) st_d.vld = 1'b0;
        if (commit_i) begin
            if (free) begin
                st_d.data = hold_i;
                st_d.vld  = 1'b1;
            end else begin
                st_d.ovr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign byte_o = st_q.data;
    assign vld_o  = st_q.vld;
    assign ovr_o  = st_q.ovr;

endmodule

// File: rtl/cbp_status_drv.sv
module cbp_status_drv
    import cbp_pkg::*;
#(
    parameter int unsigned DATA_W = CBP_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_act_i,
    input  logic              busy_i,
    output logic [DATA_W-1:0] bus_o,
    output logic              oe_o
);

    localparam logic [DATA_W-2:0] FILL = '1;

    logic oe_d, oe_q;

    always_comb begin
        oe_d = rd_act_i;
        // Top line carries ready, the rest are pulled high
        bus_o = oe_q ? {!busy_i, FILL} : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) oe_q <= 1'b0;
        else        oe_q <= oe_d;
    end

    assign oe_o = oe_q;

endmodule

// File: rtl/cfg_byte_port.sv
module cfg_byte_port
    import cbp_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sel_n_i,
    input  logic                  sel_i,
    input  logic                  wr_n_i,
    input  logic                  rd_n_i,
    input  logic [CBP_DATA_W-1:0] bus_i,
    output logic [CBP_DATA_W-1:0] bus_o,
    output logic                  bus_oe_o,
    output logic [CBP_DATA_W-1:0] byte_o,
    output logic                  byte_vld_o,
    input  logic                  byte_ack_i,
    output logic                  overrun_o
);

    cbp_pins_t             pins_raw, pins_s;
    logic                  commit;
    logic                  rd_act;
    logic [CBP_DATA_W-1:0] hold;

    assign pins_raw = '{sel_n: sel_n_i, sel: sel_i, wr_n: wr_n_i,
                        rd_n: rd_n_i, bus: bus_i};

    cbp_sync #(
        .W       (CBP_PINS_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (CBP_PINS_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pins_raw),
        .sync_o  (pins_s)
    );

    cbp_strobe_decode #(.DATA_W(CBP_DATA_W)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_n_s  (pins_s.sel_n),
        .sel_s    (pins_s.sel),
        .wr_n_s   (pins_s.wr_n),
        .rd_n_s   (pins_s.rd_n),
        .bus_s    (pins_s.bus),
        .commit_o (commit),
        .hold_o   (hold),
        .rd_act_o (rd_act)
    );

    cbp_byte_buffer #(.DATA_W(CBP_DATA_W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit),
        .hold_i   (hold),
        .ack_i    (byte_ack_i),
        .byte_o   (byte_o),
        .vld_o    (byte_vld_o),
        .ovr_o    (overrun_o)
    );

    cbp_status_drv #(.DATA_W(CBP_DATA_W)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_act_i (rd_act),
        .busy_i   (byte_vld_o),
        .bus_o    (bus_o),
        .oe_o     (bus_oe_o)
    );

endmodule

// File: rtl/cfg_byte_port_chk.sv
module cfg_byte_port_chk
    import cbp_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic [CBP_DATA_W-1:0] bus_o,
    input logic                  bus_oe_o,
    input logic [CBP_DATA_W-1:0] byte_o,
    input logic                  byte_vld_o,
    input logic                  byte_ack_i,
    input logic                  overrun_o
);

    // R3
    status_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe_o |-> (bus_o[CBP_DATA_W-1] == !byte_vld_o));

    // R4
    status_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe_o |-> (&bus_o[CBP_DATA_W-2:0]));

    // R6
    pending_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld_o && !byte_ack_i) |=> byte_vld_o);

    // R10
    byte_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld_o && !byte_ack_i) |=> $stable(byte_o));

    // R7
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> overrun_o);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe_o |-> (bus_o == '0));

endmodule

bind cfg_byte_port cfg_byte_port_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_o      (bus_o),
    .bus_oe_o   (bus_oe_o),
    .byte_o     (byte_o),
    .byte_vld_o (byte_vld_o),
    .byte_ack_i (byte_ack_i),
    .overrun_o  (overrun_o)
);

// File: tb/cfg_byte_port_test.sv
module cfg_byte_port_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_n_i = 1'b1, sel_i = 1'b0, wr_n_i = 1'b1, rd_n_i = 1'b1;
    logic [7:0] bus_i = 8'h00;
    logic [7:0] bus_o, byte_o;
    logic       bus_oe_o, byte_vld_o, overrun_o;
    logic       byte_ack_i = 1'b0;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #4 clk = ~clk;   // 125 MHz

    cfg_byte_port uut (
        .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n_i), .sel_i(sel_i),
        .wr_n_i(wr_n_i), .rd_n_i(rd_n_i), .bus_i(bus_i), .bus_o(bus_o),
        .bus_oe_o(bus_oe_o), .byte_o(byte_o), .byte_vld_o(byte_vld_o),
        .byte_ack_i(byte_ack_i), .overrun_o(overrun_o)
    );

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        sel_n_i = 1'b1; sel_i = 1'b0; wr_n_i = 1'b1; rd_n_i = 1'b1;
        byte_ack_i = 1'b0;
        wait_cyc(2);
        rst_n = 1'b1;
        wait_cyc(1);
    endtask

    task automatic write_byte(input logic [7:0] v, input logic sn, input logic s);
        @(negedge clk);
        sel_n_i = sn; sel_i = s; bus_i = v; wr_n_i = 1'b0;
        wait_cyc(3);
        wr_n_i = 1'b1;
        wait_cyc(4);
        sel_n_i = 1'b1; sel_i = 1'b0;
        wait_cyc(3);
    endtask

    task automatic read_status(input string req, input logic exp_oe,
                               input logic [7:0] exp_bus, input logic sn,
                               input logic s);
        @(negedge clk);
        sel_n_i = sn; sel_i = s; rd_n_i = 1'b0;
        wait_cyc(4);
        check({req, " oe"}, bus_oe_o, exp_oe);
        if (exp_oe) check({req, " bus"}, bus_o, exp_bus);
        rd_n_i = 1'b1;
        wait_cyc(4);
        check("R9 oe released", bus_oe_o, 1'b0);
        sel_n_i = 1'b1; sel_i = 1'b0;
        wait_cyc(2);
    endtask

    task automatic ack_byte();
        @(negedge clk);
        byte_ack_i = 1'b1;
        wait_cyc(1);
        byte_ack_i = 1'b0;
        check("R6 vld drops after ack", byte_vld_o, 1'b0);
    endtask

    task automatic t_reset();
        do_reset();
        check("R9 reset oe", bus_oe_o, 1'b0);
        check("R9 reset vld", byte_vld_o, 1'b0);
        check("R9 reset overrun", overrun_o, 1'b0);
    endtask

    task automatic t_deselected();
        write_byte(8'hA5, 1'b1, 1'b1);
        check("R1 sel_n high write ignored", byte_vld_o, 1'b0);
        write_byte(8'hA5, 1'b0, 1'b0);
        check("R1 sel low write ignored", byte_vld_o, 1'b0);
        read_status("R1 deselected read", 1'b0, 8'h00, 1'b1, 1'b0);
    endtask

    task automatic t_write_read();
        read_status("R3 ready", 1'b1, 8'hFF, 1'b0, 1'b1);
        write_byte(8'h3C, 1'b0, 1'b1);
        check("R2 byte", byte_o, 8'h3C);
        check("R2 vld", byte_vld_o, 1'b1);
        read_status("R4 busy status", 1'b1, 8'h7F, 1'b0, 1'b1);
        wait_cyc(5);
        check("R6 vld held", byte_vld_o, 1'b1);
        check("R10 byte held", byte_o, 8'h3C);
        ack_byte();
        read_status("R3 ready again", 1'b1, 8'hFF, 1'b0, 1'b1);
    endtask

    task automatic t_both_strobes();
        @(negedge clk);
        sel_n_i = 1'b0; sel_i = 1'b1; bus_i = 8'h96;
        wr_n_i = 1'b0; rd_n_i = 1'b0;
        wait_cyc(5);
        check("R5 no drive during write", bus_oe_o, 1'b0);
        wr_n_i = 1'b1; rd_n_i = 1'b1;
        wait_cyc(5);
        check("R5 byte captured", byte_o, 8'h96);
        check("R5 vld", byte_vld_o, 1'b1);
        sel_n_i = 1'b1; sel_i = 1'b0;
        ack_byte();
    endtask

    task automatic t_overrun();
        write_byte(8'h11, 1'b0, 1'b1);
        check("R7 overrun clear", overrun_o, 1'b0);
        write_byte(8'h22, 1'b0, 1'b1);
        check("R7 byte kept", byte_o, 8'h11);
        check("R7 overrun set", overrun_o, 1'b1);
        ack_byte();
        wait_cyc(3);
        check("R7 overrun sticky", overrun_o, 1'b1);
        do_reset();
        check("R7 overrun reset", overrun_o, 1'b0);
    endtask

    task automatic t_collision();
        write_byte(8'h5A, 1'b0, 1'b1);
        @(negedge clk);
        sel_n_i = 1'b0; sel_i = 1'b1; bus_i = 8'hC3; wr_n_i = 1'b0;
        wait_cyc(3);
        wr_n_i = 1'b1;          // commit is live two edges later
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        byte_ack_i = 1'b1;      // sampled on the commit edge
        wait_cyc(1);
        byte_ack_i = 1'b0;
        check("R8 new byte", byte_o, 8'hC3);
        check("R8 vld", byte_vld_o, 1'b1);
        check("R8 no overrun", overrun_o, 1'b0);
        sel_n_i = 1'b1; sel_i = 1'b0;
        wait_cyc(2);
        ack_byte();
    endtask

    initial begin
        t_reset();
        t_deselected();
        t_write_read();
        t_both_strobes();
        t_overrun();
        t_collision();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule